// File: doc/BRIEF.md
# Byte ALU with Compare Flags

This block is the arithmetic and logic unit of a small eight-bit processor core. On each accepted request it takes an instruction opcode and the two register operands, A and B, and one clock later returns the value to be written back into register A, a write strobe for that register, the new condition flags, and two exception strobes: one that asks the core to halt and one that marks an opcode this unit does not execute.

The unit covers integer add, subtract, multiply and remainder, the bitwise operations AND, OR, XOR and NOT, logical shifts in both directions by a count held in B, and an unsigned three-way compare. Compare writes only the flags; every other operation leaves the flags as the core supplies them on `flags_in`. A remainder with a zero divisor does not produce a value: it raises the halt strobe and suppresses the write.

Top module: `byte_alu`

## Requirements
- R1: Opcodes 0xA0 (add), 0xA1 (subtract) and 0xA2 (multiply) return A+B, A-B and A*B truncated to 8 bits, with `wr_en` high.
- R2: Opcodes 0xA8 (AND), 0xAA (OR) and 0xAB (XOR) return the bitwise combination of A and B with `wr_en` high.
- R3: Opcode 0x69 (NOT) returns the bitwise inverse of A with `wr_en` high; the value of B has no effect on any output.
- R4: Opcode 0xAC shifts A left and 0xAD shifts A right by the unsigned count in B, filling vacated bits with zero; any count of 8 or more returns zero.
- R5: Opcode 0xA4 with a nonzero B returns the remainder of A divided by B (unsigned) with `wr_en` high and `halt` low.
- R6: Opcode 0xA4 with B equal to zero raises `halt`, keeps `wr_en` low and returns A unchanged on `result`.
- R7: Opcode 0xA7 (compare) drives `flags_out` to 3'b100 when A<B, 3'b010 when A>B and 3'b001 when A==B, compared unsigned; `wr_en` stays low and `result` equals A.
- R8: Every opcode other than 0xA7 copies `flags_in` to `flags_out` unchanged.
- R9: Any opcode not listed in R1 to R7 raises `err`, keeps `wr_en` and `halt` low, passes `flags_in` through and returns A on `result`.
- R10: Outputs are registered: a request presented with `in_valid` high at one rising edge appears with `out_valid` high after that edge; while `out_valid` is low, `wr_en`, `halt` and `err` are low.
- R11: While synchronous reset `rst` is high, all outputs are driven to zero at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe for the operands below |
| opcode | input | 8 | Instruction opcode |
| a_val | input | 8 | Register A operand |
| b_val | input | 8 | Register B operand (shift count, divisor) |
| flags_in | input | 3 | Current flags {less, greater, equal} |
| out_valid | output | 1 | Result of the previous request is present |
| result | output | 8 | Value for register A |
| wr_en | output | 1 | Write `result` into register A |
| flags_out | output | 3 | Flags after the operation {less, greater, equal} |
| halt | output | 1 | Remainder by zero, stop the core |
| err | output | 1 | Opcode not executed by this unit |

## Verification
A wrong decode shows one cycle after the request as a wrong `result`, a raised `err` on a legal opcode, or a missing `wr_en`; the scoreboard compares every field of every returned item, so each fault surfaces at the first request that exercises it. A fault in the compare or flag pass-through logic appears on `flags_out` in that same cycle, and the bench chooses distinct `flags_in` values so that a stale or swapped flag code cannot match by accident. Corrupted output registers show as a nonzero output during reset or as strobes while `out_valid` is low, both checked at the ports.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

    localparam logic [7:0] OPC_ADD = 8'hA0;
    localparam logic [7:0] OPC_SUB = 8'hA1;
    localparam logic [7:0] OPC_MUL = 8'hA2;
    localparam logic [7:0] OPC_MOD = 8'hA4;
    localparam logic [7:0] OPC_CMP = 8'hA7;
    localparam logic [7:0] OPC_AND = 8'hA8;
    localparam logic [7:0] OPC_OR  = 8'hAA;
    localparam logic [7:0] OPC_XOR = 8'hAB;
    localparam logic [7:0] OPC_SHL = 8'hAC;
    localparam logic [7:0] OPC_SHR = 8'hAD;
    localparam logic [7:0] OPC_NOT = 8'h69;

    localparam int FLAG_W = 3;
    localparam int FL_LT  = 2;
    localparam int FL_GT  = 1;
    localparam int FL_EQ  = 0;

    typedef enum logic [3:0] {
        K_ADD, K_SUB, K_MUL, K_MOD,
        K_AND, K_OR,  K_XOR, K_NOT,
        K_SHL, K_SHR, K_CMP, K_BAD
    } op_kind_e;

    // Build a one-hot compare code from the two strict relations.
    function automatic logic [FLAG_W-1:0] cmp_code(input logic lt, input logic gt);
        logic [FLAG_W-1:0] f;
        f        = '0;
        f[FL_LT] = lt;
        f[FL_GT] = gt;
        f[FL_EQ] = !lt && !gt;
        return f;
    endfunction

endpackage

// File: rtl/byte_alu_decode.sv
module byte_alu_decode
    import byte_alu_pkg::*;
(
    input  logic [7:0] opcode,
    output op_kind_e   kind
);
    always_comb begin
        case (opcode)
            OPC_ADD: kind = K_ADD;
            OPC_SUB: kind = K_SUB;
            OPC_MUL: kind = K_MUL;
            OPC_MOD: kind = K_MOD;
            OPC_CMP: kind = K_CMP;
            OPC_AND: kind = K_AND;
            OPC_OR:  kind = K_OR;
            OPC_XOR: kind = K_XOR;
            OPC_SHL: kind = K_SHL;
            OPC_SHR: kind = K_SHR;
            OPC_NOT: kind = K_NOT;
            default: kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/byte_alu_compare.sv
module byte_alu_compare
    import byte_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_b,
    output logic [FLAG_W-1:0] code
);
    logic lt;
    logic gt;

    always_comb begin
        lt   = op_a < op_b;
        gt   = op_a > op_b;
        code = cmp_code(lt, gt);
    end
endmodule

// File: rtl/byte_alu_datapath.sv
module byte_alu_datapath
    import byte_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  op_kind_e     kind,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] value,
    output logic         div_zero
);
    localparam int SH_W = $clog2(W);

    logic [W:0]      b_ext;
    logic            wide_shift;
    logic [SH_W-1:0] sh_amt;
    logic [W-1:0]    shl_val;
    logic [W-1:0]    shr_val;

    always_comb begin
        b_ext      = {1'b0, op_b};
        wide_shift = b_ext >= (W+1)'(W);
        sh_amt     = op_b[SH_W-1:0];
        shl_val    = wide_shift ? '0 : (op_a << sh_amt);
        shr_val    = wide_shift ? '0 : (op_a >> sh_amt);
    end

    always_comb begin
        div_zero = 1'b0;
        value    = op_a;
        case (kind)
            K_ADD: value = op_a + op_b;
            K_SUB: value = op_a - op_b;
            K_MUL: value = W'(op_a * op_b);
            K_MOD: begin
                if (op_b == '0) begin
                    div_zero = 1'b1;
                    value    = op_a;
                end else begin
                    value = op_a % op_b;
                end
            end
            K_AND: value = op_a & op_b;
            K_OR:  value = op_a | op_b;
            K_XOR: value = op_a ^ op_b;
            K_NOT: value = ~op_a;
            K_SHL: value = shl_val;
            K_SHR: value = shr_val;
            default: value = op_a;
        endcase
    end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import byte_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        opcode,
    input  logic [W-1:0]      a_val,
    input  logic [W-1:0]      b_val,
    input  logic [FLAG_W-1:0] flags_in,
    output logic              out_valid,
    output logic [W-1:0]      result,
    output logic              wr_en,
    output logic [FLAG_W-1:0] flags_out,
    output logic              halt,
    output logic              err
);
    typedef struct packed {
        logic              valid;
        logic [W-1:0]      data;
        logic              wr;
        logic [FLAG_W-1:0] flags;
        logic              halt;
        logic              err;
    } alu_res_t;

    op_kind_e          kind;
    logic [W-1:0]      dp_value;
    logic              dp_div_zero;
    logic [FLAG_W-1:0] cmp_flags;
    alu_res_t          res_d;
    alu_res_t          res_q;

    byte_alu_decode u_decode (
        .opcode (opcode),
        .kind   (kind)
    );

    byte_alu_datapath #(.W(W)) u_datapath (
        .kind     (kind),
        .op_a     (a_val),
        .op_b     (b_val),
        .value    (dp_value),
        .div_zero (dp_div_zero)
    );

    byte_alu_compare #(.W(W)) u_compare (
        .op_a (a_val),
        .op_b (b_val),
        .code (cmp_flags)
    );

    always_comb begin
        res_d.valid = in_valid;
        res_d.data  = (kind == K_CMP) ? a_val : dp_value;
        res_d.flags = (kind == K_CMP) ? cmp_flags : flags_in;
        res_d.halt  = in_valid && (kind == K_MOD) && dp_div_zero;
        res_d.err   = in_valid && (kind == K_BAD);
        res_d.wr    = in_valid && (kind != K_BAD) && (kind != K_CMP)
                      && !((kind == K_MOD) && dp_div_zero);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign result    = res_q.data;
    assign wr_en     = res_q.wr;
    assign flags_out = res_q.flags;
    assign halt      = res_q.halt;
    assign err       = res_q.err;

    // R6: a halting remainder never writes the register
    a_r6_halt_no_write: assert property (@(posedge clk) disable iff (rst)
        halt |-> !wr_en);

    // R9: an unexecuted opcode has no side effect besides the strobe
    a_r9_err_no_side: assert property (@(posedge clk) disable iff (rst)
        err |-> (!wr_en && !halt && flags_out == $past(flags_in)));

    // R7: compare leaves exactly one flag set and writes nothing
    a_r7_cmp_onehot: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(opcode) == OPC_CMP) |-> ($countones(flags_out) == 1 && !wr_en));

    // R10: a valid output is always caused by a request one edge before
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R10: strobes stay low while no result is presented
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!wr_en && !halt && !err));

    // R4: wide shift counts clear the result
    a_r4_wide_shift_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ($past(opcode) == OPC_SHL || $past(opcode) == OPC_SHR)
         && $past(b_val) >= W) |-> (result == '0));
endmodule

// File: tb/byte_alu_bench.sv
`timescale 1ns/1ps
module byte_alu_bench;

    typedef struct {
        logic [7:0] data;
        logic       wr;
        logic [2:0] flags;
        logic       halt;
        logic       err;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] opcode = 8'h00;
    logic [7:0] a_val = 8'h00;
    logic [7:0] b_val = 8'h00;
    logic [2:0] flags_in = 3'b000;
    logic       out_valid;
    logic [7:0] result;
    logic       wr_en;
    logic [2:0] flags_out;
    logic       halt;
    logic       err;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    byte_alu u_byte_alu (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .opcode    (opcode),
        .a_val     (a_val),
        .b_val     (b_val),
        .flags_in  (flags_in),
        .out_valid (out_valid),
        .result    (result),
        .wr_en     (wr_en),
        .flags_out (flags_out),
        .halt      (halt),
        .err       (err)
    );

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [7:0] op, input logic [7:0] a,
                                   input logic [7:0] b, input logic [2:0] fi,
                                   input string tag);
        exp_t e;
        int   ia;
        int   ib;
        ia = int'(a);
        ib = int'(b);
        e.data = a; e.wr = 1'b1; e.flags = fi; e.halt = 1'b0; e.err = 1'b0; e.tag = tag;
        case (op)
            8'hA0: e.data = 8'((ia + ib) % 256);
            8'hA1: e.data = 8'((ia - ib + 256) % 256);
            8'hA2: e.data = 8'((ia * ib) % 256);
            8'hA4: if (ib == 0) begin e.halt = 1'b1; e.wr = 1'b0; end
                   else e.data = 8'(ia % ib);
            8'hA7: begin
                e.wr = 1'b0;
                e.flags = (ia < ib) ? 3'b100 : (ia > ib) ? 3'b010 : 3'b001;
            end
            8'hA8: e.data = a & b;
            8'hAA: e.data = a | b;
            8'hAB: e.data = a ^ b;
            8'h69: e.data = 8'(255 - ia);
            8'hAC: e.data = (ib >= 8) ? 8'd0 : 8'((ia * (1 << ib)) % 256);
            8'hAD: e.data = (ib >= 8) ? 8'd0 : 8'(ia / (1 << ib));
            default: begin e.err = 1'b1; e.wr = 1'b0; end
        endcase
        return e;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Driver: present one request for one cycle and queue its expectation.
    task automatic drive(input logic [7:0] op, input logic [7:0] a,
                         input logic [7:0] b, input logic [2:0] fi, input string tag);
        @(negedge clk);
        sb_q.push_back(model(op, a, b, fi, tag));
        in_valid = 1'b1;
        opcode   = op;
        a_val    = a;
        b_val    = b;
        flags_in = fi;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            opcode   = 8'hA0;
            a_val    = 8'hFF;
            b_val    = 8'h00;
        end
    endtask

    // Monitor: compare each presented result with the oldest expectation.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R10", "unexpected out_valid", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({result, wr_en, flags_out, halt, err} == {e.data, e.wr, e.flags, e.halt, e.err},
                      e.tag, "data/wr/flags/halt/err",
                      {19'd0, result, wr_en, flags_out, halt, err},
                      {19'd0, e.data, e.wr, e.flags, e.halt, e.err});
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check({out_valid, result, wr_en, flags_out, halt, err} == 15'd0, "R11", "reset outputs",
              {17'd0, out_valid, result, wr_en, flags_out, halt, err}, 32'd0);
        rst = 1'b0;
        idle(2);
        // R10: idle outputs
        check(!out_valid && !wr_en && !halt && !err, "R10", "idle strobes",
              {28'd0, out_valid, wr_en, halt, err}, 32'd0);

        drive(8'hA0, 8'd200, 8'd100, 3'b010, "R1");   // add wraps to 44
        drive(8'hA1, 8'd5,   8'd9,   3'b100, "R1");   // subtract wraps to 252
        drive(8'hA2, 8'd20,  8'd13,  3'b001, "R1");   // multiply truncates to 4
        drive(8'hA8, 8'hF0,  8'h3C,  3'b000, "R2");
        drive(8'hAA, 8'hF0,  8'h0C,  3'b110, "R2");
        drive(8'hAB, 8'hFF,  8'h5A,  3'b011, "R2");
        drive(8'h69, 8'h5A,  8'h00,  3'b001, "R3");
        drive(8'h69, 8'h5A,  8'hFF,  3'b001, "R3");   // B differs, same output
        drive(8'hAC, 8'h81,  8'd1,   3'b000, "R4");
        drive(8'hAC, 8'h81,  8'd8,   3'b000, "R4");
        drive(8'hAD, 8'h80,  8'd7,   3'b000, "R4");
        drive(8'hAD, 8'hFF,  8'd200, 3'b000, "R4");
        drive(8'hAC, 8'h01,  8'd7,   3'b000, "R4");
        idle(1);
        drive(8'hA4, 8'd200, 8'd7,   3'b100, "R5");
        drive(8'hA4, 8'd6,   8'd9,   3'b000, "R5");
        drive(8'hA4, 8'd77,  8'd0,   3'b010, "R6");
        drive(8'hA7, 8'd3,   8'd9,   3'b001, "R7");
        drive(8'hA7, 8'h80,  8'h01,  3'b100, "R7");   // unsigned: greater
        drive(8'hA7, 8'd42,  8'd42,  3'b100, "R7");
        drive(8'hA0, 8'd1,   8'd1,   3'b111, "R8");
        drive(8'hAD, 8'd4,   8'd1,   3'b101, "R8");
        drive(8'h00, 8'd9,   8'd3,   3'b011, "R9");
        drive(8'hA3, 8'd9,   8'd3,   3'b110, "R9");
        drive(8'hFF, 8'd0,   8'd0,   3'b000, "R9");
        idle(3);
        // R10: every queued request returned exactly once
        check(sb_q.size() == 0, "R10", "pending results", sb_q.size(), 32'd0);
        check(!out_valid && !wr_en && !halt && !err, "R10", "idle strobes after traffic",
              {28'd0, out_valid, wr_en, halt, err}, 32'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule